// File: doc/BRIEF.md
# Double-Buffered Slice Serializing Output Port

This block drives a parallel group of output pins from a stream of 32-bit words. A client hands over words with a valid/ready handshake. The port then puts each word on the pins as a run of port-width slices, one slice for each tick of the port clock. Ticks come from outside as a single-cycle strobe in the block's own clock domain, nominally one every 40 ns. The pin width is a parameter set to 8 or 16. A word therefore lasts four ticks (160 ns) on an 8-bit port and two ticks (80 ns) on a 16-bit port.

Two registers sit between the client and the pins. A holding register takes the next word while a shift register is still emitting the current one. This gives a continuous stream as long as the client refills the holding register before the current word runs out. If a tick finds no word in either register, the pins keep their last value and a sticky underflow flag is raised. An enable input freezes the emission without blocking the handshake. There is no other timed-start logic.

Top module: `sser_port`

## Requirements
- R1: During and directly after reset, `pins_o` is all zeros, `word_ready_o` is 1 and `underflow_o` is 0.
- R2: `word_ready_o` is 1 exactly when the holding register is empty. A word is taken on a rising edge where `word_valid_i` and `word_ready_o` are both 1. A word offered while `word_ready_o` is 0 is dropped and never appears on the pins.
- R3: The slices of a word come out least significant first. On the s-th enabled tick of a word (s counted from 0), `pins_o` takes `word[s*PIN_W +: PIN_W]` at the clock edge where the tick is sampled.
- R4: Each word occupies exactly WORD_W/PIN_W enabled ticks: 2 for a 16-bit port and 4 for an 8-bit port.
- R5: If the holding register is full when a word's last slice has been emitted, the next enabled tick emits slice 0 of the held word. No slice is repeated or skipped, and the holding register becomes empty in that same cycle.
- R6: An enabled tick that finds no word in progress and no word held, after at least one word has been emitted, leaves `pins_o` unchanged and sets `underflow_o`. The flag stays at 1 until reset, even after new words arrive.
- R7: Enabled ticks that arrive before the first word has been accepted leave `pins_o` at zero and do not set `underflow_o`.
- R8: While `enable_i` is 0, ticks are ignored: `pins_o` and the slice position within the current word do not change. Words can still be accepted into the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable_i | input | 1 | Allows ticks to advance the output |
| tick_i | input | 1 | Single-cycle port clock tick strobe |
| word_valid_i | input | 1 | Client offers a word |
| word_data_i | input | WORD_W (32) | Word offered by the client |
| word_ready_o | output | 1 | Holding register empty, so a word can be taken |
| pins_o | output | PIN_W (16) | Parallel pin pattern |
| underflow_o | output | 1 | Sticky flag: a tick found no data |

## Verification
The main streaming function is driven with a table of words that have a distinct value in every slice, such as 0x1111_2222 and 0xDEAD_BEEF. A swapped slice order, a repeated or skipped slice, or a gap at a word boundary then shows up as a wrong pin value on a particular tick. A tick every cycle is used while the holding register is refilled as soon as it frees, which exposes any one-tick hole in the handoff. Directed tests cover the following cases:
- ticks before any data, which tells an underflow apart from the idle start;
- a word offered while the holding register is full, which must be dropped;
- enable dropped in the middle of a word, which checks that the slice position is kept;
- a tick with nothing left, to check the sticky flag and that the pins hold their value.

// File: rtl/sser_pkg.sv
// Package: shared helpers for the slice serializing port.
// Assumes the word width is a whole multiple of the pin width.
package sser_pkg;

    // Number of pin slices that make up one client word.
    function automatic int slice_count(input int word_w, input int pin_w);
        return word_w / pin_w;
    endfunction

endpackage

// File: rtl/sser_hold_reg.sv
// Holding register: takes one client word through a valid/ready handshake
// and keeps it until the shifter takes it.
// Assumes: take_i is only raised while out_valid_o is 1.
module sser_hold_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic [WORD_W-1:0] in_data_i,
    output logic              in_ready_o,
    input  logic              take_i,
    output logic              out_valid_o,
    output logic [WORD_W-1:0] out_data_o
);
    logic              full_q;
    logic [WORD_W-1:0] data_q;
    logic              accept;

    assign in_ready_o  = !full_q;
    assign accept      = in_valid_i && !full_q;
    assign out_valid_o = full_q;
    assign out_data_o  = data_q;

    // Fill on accept; empty when the shifter takes the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            full_q <= 1'b1;
            data_q <= in_data_i;
        end else if (take_i) begin
            full_q <= 1'b0;
        end
    end

    // R2
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> !in_ready_o);

    // R5
    take_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> in_ready_o);

endmodule

// File: rtl/sser_slice_shifter.sv
// Slice shifter: on each step, puts the next PIN_W slice of the current word
// on the pins, least significant first. When a word is used up, it loads the
// held word if one is present, or else flags underflow and keeps the pins.
// Assumes: step_i is already qualified by enable.
module sser_slice_shifter #(
    parameter int WORD_W = 32,
    parameter int PIN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              load_valid_i,
    input  logic [WORD_W-1:0] load_data_i,
    output logic              load_take_o,
    output logic [PIN_W-1:0]  pins_o,
    output logic              underflow_o
);
    localparam int SLICES = sser_pkg::slice_count(WORD_W, PIN_W);
    localparam int CNT_W  = (SLICES > 1) ? $clog2(SLICES) : 1;

    logic [WORD_W-1:0] shift_q;
    logic [CNT_W-1:0]  remain_q;
    logic [PIN_W-1:0]  pins_q;
    logic              started_q;
    logic              underflow_q;
    logic              busy;

    assign busy        = (remain_q != '0);
    assign load_take_o = step_i && !busy && load_valid_i;
    assign pins_o      = pins_q;
    assign underflow_o = underflow_q;

    // Advance one slice per step, reload from the holding register, or flag underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q     <= '0;
            remain_q    <= '0;
            pins_q      <= '0;
            started_q   <= 1'b0;
            underflow_q <= 1'b0;
        end else if (step_i) begin
            if (busy) begin
                pins_q   <= shift_q[PIN_W-1:0];
                shift_q  <= shift_q >> PIN_W;
                remain_q <= remain_q - 1'b1;
            end else if (load_valid_i) begin
                pins_q    <= load_data_i[PIN_W-1:0];
                shift_q   <= load_data_i >> PIN_W;
                remain_q  <= CNT_W'(SLICES - 1);
                started_q <= 1'b1;
            end else if (started_q) begin
                underflow_q <= 1'b1;
            end
        end
    end

    // R6
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_q |=> underflow_q);

    // R7
    idle_pins_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> (pins_q == '0 && !underflow_q));

    // R6
    underflow_holds_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !busy && !load_valid_i) |=> $stable(pins_q));

endmodule

// File: rtl/sser_port.sv
// Top of the double-buffered serializing output port. A client word goes
// into the holding register and then to the slice shifter, which drives the
// pins one PIN_W slice per enabled tick.
// Assumes: tick_i is a one-cycle strobe in the clk domain; PIN_W is 8 or 16.
module sser_port #(
    parameter int WORD_W = 32,
    parameter int PIN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              tick_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_data_i,
    output logic              word_ready_o,
    output logic [PIN_W-1:0]  pins_o,
    output logic              underflow_o
);
    logic              step;
    logic              hold_valid;
    logic [WORD_W-1:0] hold_data;
    logic              hold_take;

    assign step = tick_i && enable_i;

    // Parameter sanity: only 8- and 16-bit ports are supported.
    initial begin
        pin_width_chk: assert ((PIN_W == 8 || PIN_W == 16) && (WORD_W % PIN_W == 0));
    end

    sser_hold_reg #(
        .WORD_W (WORD_W)
    ) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (word_valid_i),
        .in_data_i   (word_data_i),
        .in_ready_o  (word_ready_o),
        .take_i      (hold_take),
        .out_valid_o (hold_valid),
        .out_data_o  (hold_data)
    );

    sser_slice_shifter #(
        .WORD_W (WORD_W),
        .PIN_W  (PIN_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (step),
        .load_valid_i (hold_valid),
        .load_data_i  (hold_data),
        .load_take_o  (hold_take),
        .pins_o       (pins_o),
        .underflow_o  (underflow_o)
    );

    // R8
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> $stable(pins_o));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pins_o == '0 && word_ready_o && !underflow_o));

endmodule

// File: tb/sser_port_bench.sv
// Bench for sser_port: a table-driven streaming test, then directed tests.
module sser_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 32;
    localparam int PIN_W      = 16;
    localparam int SLICES     = WORD_W / PIN_W;
    localparam int NWORDS     = 4;
    localparam logic [WORD_W-1:0] WORDS [NWORDS] = '{
        32'h1111_2222, 32'hDEAD_BEEF, 32'h0000_FFFF, 32'h8001_7FFE
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable_i = 1'b1;
    logic              tick_i = 1'b0;
    logic              word_valid_i = 1'b0;
    logic [WORD_W-1:0] word_data_i = '0;
    logic              word_ready_o;
    logic [PIN_W-1:0]  pins_o;
    logic              underflow_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sser_port #(.WORD_W(WORD_W), .PIN_W(PIN_W)) u_sser_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .tick_i       (tick_i),
        .word_valid_i (word_valid_i),
        .word_data_i  (word_data_i),
        .word_ready_o (word_ready_o),
        .pins_o       (pins_o),
        .underflow_o  (underflow_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply inputs for one cycle, then return at the next falling edge.
    task automatic drive(input logic t, input logic v, input logic [WORD_W-1:0] d);
        tick_i       = t;
        word_valid_i = v;
        word_data_i  = d;
        @(negedge clk);
    endtask

    function automatic logic [PIN_W-1:0] slice_of(input logic [WORD_W-1:0] w, input int s);
        return w[s*PIN_W +: PIN_W];
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int nxt;
        logic [PIN_W-1:0] last;
        @(negedge clk);
        drive(0, 0, '0);
        // R1: reset state
        check("R1 pins", 32'(pins_o), 32'h0);
        check("R1 ready", 32'(word_ready_o), 32'h1);
        check("R1 underflow", 32'(underflow_o), 32'h0);
        rst_n = 1'b1;

        // R7: ticks before any word
        for (int i = 0; i < 3; i++) drive(1, 0, '0);
        check("R7 pins", 32'(pins_o), 32'h0);
        check("R7 underflow", 32'(underflow_o), 32'h0);

        // R3 R4 R5: table-driven stream, tick every cycle, refill on ready
        drive(0, 1, WORDS[0]);
        check("R2 ready after fill", 32'(word_ready_o), 32'h0);
        nxt = 1;
        for (int k = 0; k < NWORDS * SLICES; k++) begin
            logic v;
            v = word_ready_o && (nxt < NWORDS);
            drive(1, v, v ? WORDS[nxt] : '0);
            if (v) nxt++;
            check($sformatf("R3 R5 tick %0d", k), 32'(pins_o),
                  32'(slice_of(WORDS[k / SLICES], k % SLICES)));
            check("R5 no underflow in stream", 32'(underflow_o), 32'h0);
        end
        last = slice_of(WORDS[NWORDS-1], SLICES-1);

        // R6: tick with nothing left
        drive(1, 0, '0);
        check("R6 underflow set", 32'(underflow_o), 32'h1);
        check("R6 pins held", 32'(pins_o), 32'(last));

        // R2: fill, then a dropped word while full
        drive(0, 1, 32'hA5A5_1234);
        check("R2 ready low when full", 32'(word_ready_o), 32'h0);
        drive(0, 1, 32'hFFFF_FFFF);
        check("R6 sticky after new word", 32'(underflow_o), 32'h1);
        check("R8 pins before tick", 32'(pins_o), 32'(last));

        // R8: enable low mid-word
        drive(1, 0, '0);
        check("R3 slice0", 32'(pins_o), 32'h1234);
        check("R2 ready after take", 32'(word_ready_o), 32'h1);
        enable_i = 1'b0;
        drive(1, 0, '0);
        drive(1, 0, '0);
        check("R8 pins frozen", 32'(pins_o), 32'h1234);
        enable_i = 1'b1;
        drive(1, 0, '0);
        check("R8 R4 slice1 resumes", 32'(pins_o), 32'hA5A5);
        drive(1, 0, '0);
        check("R2 dropped word absent", 32'(pins_o), 32'hA5A5);
        check("R6 still set", 32'(underflow_o), 32'h1);

        // R8: accept while disabled
        enable_i = 1'b0;
        drive(1, 1, 32'h0F0F_F0F0);
        check("R8 accept while disabled", 32'(word_ready_o), 32'h0);
        check("R8 pins unchanged", 32'(pins_o), 32'hA5A5);
        enable_i = 1'b1;
        drive(1, 0, '0);
        check("R3 new word slice0", 32'(pins_o), 32'hF0F0);

        // R1: reset again clears the flag and pins
        rst_n = 1'b0;
        drive(0, 0, '0);
        check("R1 reset pins", 32'(pins_o), 32'h0);
        check("R1 reset underflow", 32'(underflow_o), 32'h0);
        check("R1 reset ready", 32'(word_ready_o), 32'h1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule